// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block multiplies two unsigned operands of `W` bits (32 by default) and returns a product of `2W` bits. It trades area for time. It has one adder of `W` bits and one combined register of `2W` bits. It works through the multiplier one bit per clock, so it needs `W` clock cycles for each multiplication.

When a start request is accepted, the block captures the multiplicand and loads the combined register. The upper half of that register is cleared and the lower half takes the multiplier. On each following cycle the block examines the register's least significant bit. If that bit is one, the multiplicand is added into the upper half. The carry out of that addition and the whole register then move one place to the right, all in the same clock edge. After the last step the register holds the full product. A one-cycle completion pulse marks that point, and the product stays on the output until the next accepted start.

A host drives `start` together with both operands for one cycle. It then waits for `done`, or for `busy` to fall, and reads `product`.

Top module: `seq_mul`

## Requirements
- R1: When `done` is high, `product` equals the unsigned product `mcand * mplier` of the operands captured at the accepted start. This includes zero operands, unit operands and all-ones operands.
- R2: In the cycle after a start is accepted, `product[2W-1:W]` is zero and `product[W-1:0]` equals the captured multiplier.
- R3: On each iteration, the next register value is the current register value, plus the multiplicand shifted left by `W` places when bit 0 of the register is one, shifted right by one bit. The sum is formed at `2W+1` bits.
- R4: The carry out of the upper-half addition is never lost. An all-ones by all-ones multiply returns `(2^W-1)^2`.
- R5: `busy` rises in the cycle after a start is accepted and stays high for exactly `W` cycles.
- R6: `done` is high for exactly one cycle. That cycle comes right after the last of the `W` iterations, and `busy` is already low in it.
- R7: A `start` that arrives while `busy` is high is ignored. The operands and the result of the running multiplication are unchanged.
- R8: While idle and without a start, `product` holds its value.
- R9: After synchronous reset, `busy`, `done` and `product` are all zero.
- R10: A start presented in the same cycle that `done` is high is accepted, so multiplications can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a new multiplication (accepted only when idle) |
| mcand | input | W | Multiplicand, captured on the accepted start |
| mplier | input | W | Multiplier, captured on the accepted start |
| busy | output | 1 | High while iterations are in progress |
| done | output | 1 | One-cycle pulse when the product is complete |
| product | output | 2W | Combined product register |

## Verification
Suppose a start is sampled at clock edge k. Then the loaded register is visible after edge k, `busy` is high from edge k through edge k+W-1, and `done` together with the final product appears after edge k+W. The bench keeps a behavioural model that advances on the same clock edges. That model uses wide arithmetic on an integer register and counts down from `W`. The bench compares `busy`, `done` and `product` against it on every falling edge, so it checks the intermediate register each iteration and not only the final value. Targeted checks then sample at those fixed offsets: the load image one cycle after the start, and the reference product when `done` is seen. Starts injected mid-run, and starts issued on the `done` cycle, test the acceptance rules.

// File: rtl/seq_mul_pkg.sv
package seq_mul_pkg;

    localparam int unsigned DEF_WIDTH = 32;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mul_state_e;

    typedef struct packed {
        logic load;   // capture operands, initialise combined register
        logic step;   // one add-and-shift iteration
    } mul_cmd_t;

endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
    import seq_mul_pkg::*;
#(
    parameter int unsigned W = DEF_WIDTH
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    output mul_cmd_t cmd,
    output logic     busy,
    output logic     done
);
    localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    mul_state_e    state_q;
    logic [CW-1:0] iter_q;
    logic          done_q;
    logic          last_iter;

    assign last_iter = (iter_q == LAST);

    always_comb begin
        cmd.load = (state_q == ST_IDLE) && start;
        cmd.step = (state_q == ST_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            iter_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        iter_q  <= '0;
                    end
                end
                ST_RUN: begin
                    iter_q <= iter_q + 1'b1;
                    if (last_iter) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q == ST_RUN);
    assign done = done_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R6
    AST_START_TO_BUSY: assert property (@(posedge clk) disable iff (rst) (!busy && start) |=> busy); // R5
    AST_LAST_TO_DONE: assert property (@(posedge clk) disable iff (rst) (busy && last_iter) |=> (done && !busy)); // R6
    AST_NOT_LAST_KEEPS_BUSY: assert property (@(posedge clk) disable iff (rst) (busy && !last_iter) |=> (busy && !done)); // R5

endmodule

// File: rtl/mul_cond_add.sv
module mul_cond_add #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] upper,
    input  logic [W-1:0] addend,
    input  logic         enable,
    output logic [W:0]   sum
);
    logic [W-1:0] gated;

    assign gated = enable ? addend : '0;
    assign sum   = {1'b0, upper} + {1'b0, gated};

    always_comb begin
        if (!enable) begin
            AST_PASS_THROUGH: assert (sum == {1'b0, upper}); // R3
        end
    end

endmodule

// File: rtl/mul_dp.sv
module mul_dp
    import seq_mul_pkg::*;
#(
    parameter int unsigned W = DEF_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  mul_cmd_t     cmd,
    input  logic [W-1:0] mcand_in,
    input  logic [W-1:0] mplier_in,
    output logic [2*W-1:0] product
);
    localparam int unsigned PW = 2 * W;

    logic [W-1:0]  mcand_q;
    logic [PW-1:0] prod_q;
    logic [W:0]    upper_sum;
    logic [PW-1:0] prod_next;

    mul_cond_add #(.W(W)) u_add (
        .upper  (prod_q[PW-1:W]),
        .addend (mcand_q),
        .enable (prod_q[0]),
        .sum    (upper_sum)
    );

    // carry lands in the MSB, remaining bits move one place right
    assign prod_next = {upper_sum, prod_q[W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q <= '0;
            prod_q  <= '0;
        end else if (cmd.load) begin
            mcand_q <= mcand_in;
            prod_q  <= {{W{1'b0}}, mplier_in};
        end else if (cmd.step) begin
            prod_q  <= prod_next;
        end
    end

    assign product = prod_q;

    AST_LOAD_IMAGE: assert property (@(posedge clk) disable iff (rst)
        cmd.load |=> (prod_q[PW-1:W] == '0 && prod_q[W-1:0] == $past(mplier_in))); // R2
    AST_MCAND_HELD: assert property (@(posedge clk) disable iff (rst)
        !cmd.load |=> $stable(mcand_q)); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cmd.load && !cmd.step) |=> $stable(prod_q)); // R8
    AST_ZERO_BIT_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (cmd.step && !prod_q[0]) |=> (prod_q == {1'b0, $past(prod_q[PW-1:1])})); // R3

endmodule

// File: rtl/seq_mul.sv
module seq_mul
    import seq_mul_pkg::*;
#(
    parameter int unsigned W = DEF_WIDTH
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] product
);
    mul_cmd_t cmd;

    mul_ctrl #(.W(W)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .cmd   (cmd),
        .busy  (busy),
        .done  (done)
    );

    mul_dp #(.W(W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .mcand_in  (mcand),
        .mplier_in (mplier),
        .product   (product)
    );

    AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (rst) done |-> $past(busy)); // R6
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst) (busy && start) |-> !cmd.load); // R7

endmodule

// File: tb/seq_mul_tb.sv
module seq_mul_tb;
    localparam int unsigned W = 32;
    localparam int unsigned PW = 2 * W;
    localparam time CLK_PERIOD = 10ns;
    localparam int WATCHDOG = 150000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [W-1:0]  mcand = '0;
    logic [W-1:0]  mplier = '0;
    logic          busy;
    logic          done;
    logic [PW-1:0] product;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    seq_mul #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .mcand(mcand), .mplier(mplier),
        .busy(busy), .done(done), .product(product)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference, advanced on the same edges
    logic          r_busy = 1'b0;
    logic          r_done = 1'b0;
    logic [PW-1:0] r_prod = '0;
    logic [W-1:0]  r_a = '0;
    logic [PW-1:0] r_exp = '0;
    int            r_left = 0;

    always @(posedge clk) begin
        logic [PW:0] t;
        if (rst) begin
            r_busy <= 1'b0; r_done <= 1'b0; r_prod <= '0; r_left <= 0;
        end else begin
            r_done <= 1'b0;
            if (r_busy) begin
                t = {1'b0, r_prod} + (r_prod[0] ? {1'b0, r_a, {W{1'b0}}} : '0);
                r_prod <= t[PW:1];
                r_left <= r_left - 1;
                if (r_left == 1) begin
                    r_busy <= 1'b0;
                    r_done <= 1'b1;
                end
            end else if (start) begin
                r_a    <= mcand;
                r_prod <= {{W{1'b0}}, mplier};
                r_exp  <= {{W{1'b0}}, mcand} * {{W{1'b0}}, mplier};
                r_busy <= 1'b1;
                r_left <= W;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            check(busy == r_busy, "R5", PW'(busy), PW'(r_busy));
            check(done == r_done, "R6", PW'(done), PW'(r_done));
            check(product == r_prod, r_busy ? "R3" : "R8", product, r_prod);
            if (r_done)
                check(product == r_exp, "R1", product, r_exp);
        end
    end

    task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b);
        start = 1'b1; mcand = a; mplier = b;
        @(negedge clk);
        start = 1'b0;
        // R2: load image one cycle after acceptance
        check(product == {{W{1'b0}}, b}, "R2", product, {{W{1'b0}}, b});
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic mul_once(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
        logic [PW-1:0] e;
        e = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        issue(a, b);
        wait_done();
        check(product == e, req, product, e);
        @(negedge clk);
    endtask

    initial begin
        while (cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        fails++; checks++;
        $display("FAIL watchdog: actual %0d expected <%0d cycles", cycles, WATCHDOG);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [PW-1:0] held;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        check(busy == 1'b0, "R9", PW'(busy), '0);
        check(done == 1'b0, "R9", PW'(done), '0);
        check(product == '0, "R9", product, '0);
        @(negedge clk);

        mul_once(32'd2, 32'd3, "R1");
        mul_once(32'd0, 32'hDEADBEEF, "R1");
        mul_once(32'h12345678, 32'd0, "R1");
        mul_once(32'd1, 32'hCAFEF00D, "R1");
        mul_once(32'h89ABCDEF, 32'd1, "R1");
        mul_once(32'hFFFFFFFF, 32'hFFFFFFFF, "R4");
        mul_once(32'hFFFFFFFF, 32'd2, "R4");
        mul_once(32'h80000000, 32'h80000000, "R4");

        // R5: busy counted for exactly W cycles
        issue(32'd7, 32'd9);
        n = 1;
        while (busy) begin @(negedge clk); if (busy) n++; end
        check(n == W, "R5", PW'(n), PW'(W));
        check(done == 1'b1, "R6", PW'(done), 1);
        @(negedge clk);

        // R7: start with other operands mid-run is ignored
        issue(32'h00010001, 32'h0000FFFF);
        repeat (5) @(negedge clk);
        start = 1'b1; mcand = 32'hFFFFFFFF; mplier = 32'hFFFFFFFF;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check(product == 64'h00010001 * 64'h0000FFFF, "R7", product, 64'h00010001 * 64'h0000FFFF);
        // R8: idle hold
        held = product;
        repeat (4) @(negedge clk);
        check(product == held, "R8", product, held);
        check(busy == 1'b0, "R7", PW'(busy), '0);

        // R10: start on the done cycle
        issue(32'd11, 32'd13);
        wait_done();
        check(product == 64'd143, "R10", product, 64'd143);
        issue(32'd17, 32'd19);
        check(busy == 1'b1, "R10", PW'(busy), 1);
        wait_done();
        check(product == 64'd323, "R10", product, 64'd323);
        @(negedge clk);

        for (int i = 0; i < 24; i++) begin
            mul_once($urandom, $urandom, "R1");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule